// File: doc/BRIEF.md
# Single-Packet Transmit/Receive Command and Status Controller

This block sits between software-visible control words and two byte-stream ports of a simple packet engine. It has one transmit packet memory and one receive packet memory, and each side handles one packet at a time. To send, software fills the transmit memory, then writes a command word that holds the octet count and a start flag. The controller reads the memory one word at a time, breaks each word into octets with the most significant byte first, and presents them on a valid/ready byte stream. It drops the start flag when the last octet has been accepted. Writing an all-zero command word while a packet is being sent abandons it.

On the receive side, incoming octets go straight into receive memory using one-hot byte-lane enables. When a clean packet ends, the controller latches its length and raises an available flag, which is also the interrupt. After that it refuses every new packet until software rearms it. Each packet refused while the flag is up sets a missed bit. Packets that end with a CRC fault or another fault set their own sticky bits and do not raise the flag.

The engine leaves reset in a held state. It does nothing until software writes a command word with the hold bit clear. Three command bits pass straight through to the MAC as bypass options. One of them, raw CRC, makes the controller refuse to start any packet shorter than a minimum frame.

Top module: `pkt_cmd_ctrl`

## Requirements
- R1: A command write made while the transmitter is idle loads length bits [10:0], start bit 14, hold bit 15 and option bits [18:16]. The start bit is set only when the hold bit is clear and the length is non-zero. Exactly `length` octets are then sent, with `tx_last` on the final one.
- R2: The start bit reads 1 and `tx_valid` stays high for the whole packet. Both are low in the cycle after the handshake of the last octet. `tx_data` and `txm_addr` hold steady while `tx_ready` is low.
- R3: Writing the all-zero word during a transmission cancels it. In the next cycle `tx_valid` is low and the command word reads 0.
- R4: After reset the command word reads 0x00008000 and the status word reads 0. While hold bit 15 is set, nothing is sent, a start request is not accepted, incoming packets are not written, and the status stays 0.
- R5: Option bits 16, 17 and 18 read back and drive `opt_mac_bypass`, `opt_crc_raw` and `opt_ipchk_off`. When bit 17 is set, a length below 64 does not start. A length of 0 never starts.
- R6: Octet k of a packet is stored in word k/4, in bits [31-8*(k%4) -: 8], for both transmit and receive. Each receive write enables exactly one byte lane.
- R7: When a packet with no fault ends, status bit 14 and `rx_irq` are 1 from the next cycle on, and status bits [10:0] hold the octet count.
- R8: While status bit 14 is set, incoming packets are not written to memory. At the end of each such packet, missed bit 15 is set and the stored length is kept.
- R9: A packet that ends with `rx_crc_err` sets bit 16. One that ends with only `rx_oth_err` sets bit 17. CRC takes priority. Neither case sets bit 14.
- R10: `stat_clr` is a write-one-to-clear strobe. Bit 0 clears the available flag and rearms the receiver, bit 1 clears the missed flag, bit 2 the CRC flag and bit 3 the other-fault flag. Strobe bits that are 0 leave their flags alone.
- R11: A non-zero command write made while the start bit is high is ignored, and the packet in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word write value |
| cmd_rdata | output | 32 | Command word readback |
| stat_clr | input | 4 | Write-one-to-clear strobes for the status flags |
| stat_rdata | output | 32 | Receive status readback |
| rx_irq | output | 1 | Receive interrupt, high while a packet is available |
| opt_mac_bypass | output | 1 | Option: no hardware MAC insertion or removal |
| opt_crc_raw | output | 1 | Option: no hardware CRC handling |
| opt_ipchk_off | output | 1 | Option: no IP header checksum checking |
| txm_addr | output | 9 | Transmit memory word address |
| txm_rdata | input | 32 | Transmit memory word, same-cycle read |
| tx_valid | output | 1 | Transmit octet valid |
| tx_data | output | 8 | Transmit octet |
| tx_last | output | 1 | Final octet of the packet |
| tx_ready | input | 1 | MAC accepts the octet |
| rx_valid | input | 1 | Receive octet valid |
| rx_data | input | 8 | Receive octet |
| rx_last | input | 1 | Final octet of the received packet |
| rx_crc_err | input | 1 | CRC fault, sampled with rx_last |
| rx_oth_err | input | 1 | Other fault, sampled with rx_last |
| rxm_we | output | 1 | Receive memory write strobe |
| rxm_addr | output | 9 | Receive memory word address |
| rxm_be | output | 4 | Receive memory byte enables, bit 3 is the most significant lane |
| rxm_wdata | output | 32 | Receive octet replicated on all lanes |

## Verification
Transmit runs use lengths of 1, 4 and 64 plus random lengths, with `tx_ready` dropped at random. These separate a wrong octet order, an off-by-one in the last-octet flag, and a start bit that falls too early or too late. Extra command writes are placed in the middle of packets: a zero word must cancel the transmission and a non-zero word must change nothing. Receive runs send a one-octet packet, clean packets of random length, a packet arriving while the receiver is locked, and packets with a CRC fault, another fault, or both. These cases show whether the length latch, the missed flag, the fault priority and the lane enables each behave independently. The hold state and the raw-CRC minimum are driven with requests that must be refused.

// File: rtl/pktc_pkg.sv
package pktc_pkg;

    localparam int CMD_GO_BIT   = 14;
    localparam int CMD_HOLD_BIT = 15;
    localparam int CMD_OPT_LSB  = 16;
    localparam int OPT_W        = 3;
    localparam int OPT_RAW_CRC  = 1;
    localparam int STAT_FLG_LSB = 14;
    localparam int FLG_W        = 4;

    typedef struct packed {
        logic [OPT_W-1:0] opts;
        logic             hold;
        logic             go;
    } tx_ctl_t;

    typedef struct packed {
        logic oth;
        logic crc;
        logic miss;
        logic avail;
    } rx_flags_t;

    function automatic logic [3:0] lane_mask(input logic [1:0] idx);
        return 4'b1000 >> idx;
    endfunction

    function automatic logic [7:0] lane_pick(input logic [31:0] w, input logic [1:0] idx);
        return w[8*(3-idx) +: 8];
    endfunction

endpackage

// File: rtl/pktc_tx_seq.sv
module pktc_tx_seq
    import pktc_pkg::*;
#(
    parameter int LEN_W   = 11,
    parameter int MIN_RAW = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    output logic             hold,
    output logic [OPT_W-1:0] opts,
    output logic [LEN_W-3:0] mem_addr,
    input  logic [31:0]      mem_rdata,
    output logic             tv,
    output logic [7:0]       td,
    output logic             tl,
    input  logic             tr
);
    localparam logic [LEN_W-1:0] ONE   = LEN_W'(1);
    localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_RAW);

    logic [LEN_W-1:0] len_q, cnt_q;
    tx_ctl_t          ctl_q;

    logic [LEN_W-1:0] w_len;
    logic [OPT_W-1:0] w_opts;
    logic             w_go, w_hold, start_ok, fire, last, cancel;

    assign w_len    = wdata[LEN_W-1:0];
    assign w_opts   = wdata[CMD_OPT_LSB +: OPT_W];
    assign w_go     = wdata[CMD_GO_BIT];
    assign w_hold   = wdata[CMD_HOLD_BIT];
    assign start_ok = w_go && !w_hold && (w_len != '0)
                      && !(w_opts[OPT_RAW_CRC] && (w_len < MIN_L));
    assign last     = (cnt_q == len_q - ONE);
    assign fire     = ctl_q.go && tr;
    assign cancel   = we && ctl_q.go && (wdata == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q <= '0;
            cnt_q <= '0;
            ctl_q <= '{opts: '0, hold: 1'b1, go: 1'b0};
        end else if (cancel) begin
            len_q <= '0;
            cnt_q <= '0;
            ctl_q <= '0;
        end else if (we && !ctl_q.go) begin
            len_q      <= w_len;
            cnt_q      <= '0;
            ctl_q.opts <= w_opts;
            ctl_q.hold <= w_hold;
            ctl_q.go   <= start_ok;
        end else if (fire) begin
            if (last) begin
                ctl_q.go <= 1'b0;
                cnt_q    <= '0;
            end else begin
                cnt_q <= cnt_q + ONE;
            end
        end
    end

    always_comb begin
        rdata                       = '0;
        rdata[LEN_W-1:0]            = len_q;
        rdata[CMD_GO_BIT]           = ctl_q.go;
        rdata[CMD_HOLD_BIT]         = ctl_q.hold;
        rdata[CMD_OPT_LSB +: OPT_W] = ctl_q.opts;
    end

    assign hold     = ctl_q.hold;
    assign opts     = ctl_q.opts;
    assign mem_addr = cnt_q[LEN_W-1:2];
    assign td       = lane_pick(mem_rdata, cnt_q[1:0]);
    assign tl       = last;
    assign tv       = ctl_q.go;

endmodule

// File: rtl/pktc_rx_wr.sv
module pktc_rx_wr
    import pktc_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic [FLG_W-1:0] clr,
    output logic [31:0]      rdata,
    output logic             irq,
    input  logic             rv,
    input  logic [7:0]       rd,
    input  logic             rl,
    input  logic             rcrc,
    input  logic             roth,
    output logic             mwe,
    output logic [LEN_W-3:0] maddr,
    output logic [3:0]       mbe,
    output logic [31:0]      mwdata
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    rx_flags_t        fl_q, nxt_fl;
    logic [LEN_W-1:0] len_q, nxt_len, cnt_q, cur;
    logic             inpkt_q, drop_q, busy_q;
    logic             first, acc, busy_drop;

    assign first     = !inpkt_q;
    assign acc       = first ? (!fl_q.avail && !hold) : !drop_q;
    assign busy_drop = first ? (fl_q.avail && !hold) : busy_q;
    assign cur       = first ? '0 : cnt_q;

    assign mwe    = rv && acc;
    assign maddr  = cur[LEN_W-1:2];
    assign mbe    = lane_mask(cur[1:0]);
    assign mwdata = {4{rd}};

    always_comb begin
        nxt_fl  = rx_flags_t'(fl_q & ~clr);
        nxt_len = len_q;
        if (rv && rl) begin
            if (acc) begin
                if (rcrc)      nxt_fl.crc = 1'b1;
                else if (roth) nxt_fl.oth = 1'b1;
                else begin
                    nxt_fl.avail = 1'b1;
                    nxt_len      = cur + ONE;
                end
            end else if (busy_drop) begin
                nxt_fl.miss = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            fl_q    <= '0;
            len_q   <= '0;
            cnt_q   <= '0;
            inpkt_q <= 1'b0;
            drop_q  <= 1'b0;
            busy_q  <= 1'b0;
        end else begin
            fl_q  <= nxt_fl;
            len_q <= nxt_len;
            if (rv) begin
                inpkt_q <= !rl;
                drop_q  <= !acc;
                busy_q  <= busy_drop;
                cnt_q   <= rl ? '0 : cur + ONE;
            end
        end
    end

    always_comb begin
        rdata                        = '0;
        rdata[LEN_W-1:0]             = len_q;
        rdata[STAT_FLG_LSB +: FLG_W] = fl_q;
    end

    assign irq = fl_q.avail;

endmodule

// File: rtl/pkt_cmd_ctrl.sv
module pkt_cmd_ctrl
    import pktc_pkg::*;
#(
    parameter int LEN_W       = 11,
    parameter int MIN_RAW_LEN = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_we,
    input  logic [31:0]      cmd_wdata,
    output logic [31:0]      cmd_rdata,
    input  logic [3:0]       stat_clr,
    output logic [31:0]      stat_rdata,
    output logic             rx_irq,
    output logic             opt_mac_bypass,
    output logic             opt_crc_raw,
    output logic             opt_ipchk_off,
    output logic [LEN_W-3:0] txm_addr,
    input  logic [31:0]      txm_rdata,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    output logic             tx_last,
    input  logic             tx_ready,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             rx_last,
    input  logic             rx_crc_err,
    input  logic             rx_oth_err,
    output logic             rxm_we,
    output logic [LEN_W-3:0] rxm_addr,
    output logic [3:0]       rxm_be,
    output logic [31:0]      rxm_wdata
);
    logic             hold;
    logic [OPT_W-1:0] opts;

    pktc_tx_seq #(.LEN_W(LEN_W), .MIN_RAW(MIN_RAW_LEN)) u_tx (
        .clk(clk), .rst(rst), .we(cmd_we), .wdata(cmd_wdata), .rdata(cmd_rdata),
        .hold(hold), .opts(opts), .mem_addr(txm_addr), .mem_rdata(txm_rdata),
        .tv(tx_valid), .td(tx_data), .tl(tx_last), .tr(tx_ready)
    );

    pktc_rx_wr #(.LEN_W(LEN_W)) u_rx (
        .clk(clk), .rst(rst), .hold(hold), .clr(stat_clr), .rdata(stat_rdata),
        .irq(rx_irq), .rv(rx_valid), .rd(rx_data), .rl(rx_last),
        .rcrc(rx_crc_err), .roth(rx_oth_err), .mwe(rxm_we), .maddr(rxm_addr),
        .mbe(rxm_be), .mwdata(rxm_wdata)
    );

    assign opt_mac_bypass = opts[0];
    assign opt_crc_raw    = opts[1];
    assign opt_ipchk_off  = opts[2];

endmodule

// File: rtl/pktc_chk.sv
module pktc_chk #(
    parameter int LEN_W = 11
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_we,
    input logic [31:0]      cmd_wdata,
    input logic [31:0]      cmd_rdata,
    input logic [31:0]      stat_rdata,
    input logic             rx_irq,
    input logic [LEN_W-3:0] txm_addr,
    input logic             tx_valid,
    input logic [7:0]       tx_data,
    input logic             tx_last,
    input logic             tx_ready,
    input logic             rx_valid,
    input logic             rx_last,
    input logic             rxm_we,
    input logic [3:0]       rxm_be
);
    logic zero_wr;
    assign zero_wr = cmd_we && (cmd_wdata == '0);

    AST_GO_FALLS: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && tx_last) |=> (!cmd_rdata[14] && !tx_valid)); // R2
    AST_GO_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !(tx_ready && tx_last) && !zero_wr) |=> (tx_valid && cmd_rdata[14])); // R2
    AST_STALL_STABLE: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready && !zero_wr) |=> ($stable(tx_data) && $stable(txm_addr))); // R2
    AST_CANCEL: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && zero_wr) |=> (cmd_rdata == '0 && !tx_valid)); // R3
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
        cmd_rdata[15] |-> (!tx_valid && !rxm_we && stat_rdata == '0)); // R4
    AST_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
        rxm_we |-> ($countones(rxm_be) == 1)); // R6
    AST_IRQ_AFTER_END: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_irq) |-> $past(rx_valid && rx_last)); // R7
    AST_LOCKED_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        stat_rdata[14] |-> !rxm_we); // R8
    AST_BUSY_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && cmd_we && !zero_wr) |=> $stable(cmd_rdata[LEN_W-1:0])); // R11

endmodule

bind pkt_cmd_ctrl pktc_chk #(.LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
    .stat_rdata(stat_rdata), .rx_irq(rx_irq), .txm_addr(txm_addr), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready), .rx_valid(rx_valid),
    .rx_last(rx_last), .rxm_we(rxm_we), .rxm_be(rxm_be)
);

// File: tb/sim_pkt_cmd_ctrl.sv
module sim_pkt_cmd_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W      = 11;
    localparam int WORDS      = 1 << (LEN_W - 2);

    logic             clk = 1'b0;
    logic             rst;
    logic             cmd_we;
    logic [31:0]      cmd_wdata, cmd_rdata, stat_rdata;
    logic [3:0]       stat_clr;
    logic             rx_irq, opt_mac_bypass, opt_crc_raw, opt_ipchk_off;
    logic [LEN_W-3:0] txm_addr, rxm_addr;
    logic [31:0]      txm_rdata, rxm_wdata;
    logic             tx_valid, tx_last, tx_ready;
    logic [7:0]       tx_data, rx_data;
    logic             rx_valid, rx_last, rx_crc_err, rx_oth_err;
    logic             rxm_we;
    logic [3:0]       rxm_be;

    logic [31:0] tx_mem [WORDS];
    logic [31:0] rx_mem [WORDS];

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_cmd_ctrl #(.LEN_W(LEN_W)) u0 (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
        .stat_clr(stat_clr), .stat_rdata(stat_rdata), .rx_irq(rx_irq),
        .opt_mac_bypass(opt_mac_bypass), .opt_crc_raw(opt_crc_raw), .opt_ipchk_off(opt_ipchk_off),
        .txm_addr(txm_addr), .txm_rdata(txm_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_last(tx_last), .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_last(rx_last), .rx_crc_err(rx_crc_err), .rx_oth_err(rx_oth_err),
        .rxm_we(rxm_we), .rxm_addr(rxm_addr), .rxm_be(rxm_be), .rxm_wdata(rxm_wdata)
    );

    assign txm_rdata = tx_mem[txm_addr];

    always @(posedge clk) begin
        if (rxm_we) begin
            for (int b = 0; b < 4; b++)
                if (rxm_be[b]) rx_mem[rxm_addr][8*b +: 8] <= rxm_wdata[8*b +: 8];
        end
    end

    function automatic logic [7:0] pat(int s, int k);
        return 8'((s * 37 + k * 13 + (k >> 4)) ^ s);
    endfunction

    function automatic logic [7:0] mem_octet(logic [31:0] w, int k);
        return w[8*(3 - (k % 4)) +: 8];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cmd_write(input logic [31:0] v);
        @(negedge clk);
        cmd_we = 1'b1; cmd_wdata = v;
        @(negedge clk);
        cmd_we = 1'b0; cmd_wdata = '0;
    endtask

    task automatic stat_write(input logic [3:0] v);
        @(negedge clk);
        stat_clr = v;
        @(negedge clk);
        stat_clr = '0;
    endtask

    task automatic tx_send(int len, int opts, int seed, int poke_at, bit cancel);
        int got = 0, guard = 0;
        bit bad_d = 0, bad_go = 0, bad_last = 0, prevlast = 0, poked = 0;
        for (int k = 0; k < len; k++) tx_mem[k/4][8*(3 - (k % 4)) +: 8] = pat(seed, k);
        cmd_write(32'(len) | 32'h4000 | (32'(opts) << 16));
        chk(cmd_rdata[14] && cmd_rdata[10:0] == 11'(len), "R1 start accepted", cmd_rdata, 32'(len) | 32'h4000);
        chk({opt_ipchk_off, opt_crc_raw, opt_mac_bypass} == 3'(opts), "R5 option outputs",
            {29'd0, opt_ipchk_off, opt_crc_raw, opt_mac_bypass}, 32'(opts));
        while (1) begin
            if (prevlast) begin
                chk(!cmd_rdata[14] && !tx_valid, "R2 go falls after last", cmd_rdata, 32'(len));
                break;
            end
            if (guard++ > 40 * len + 100) begin
                chk(0, "R2 transmission hung", 32'(got), 32'(len));
                break;
            end
            if (!tx_valid) bad_go = 1;
            if (got == poke_at && !poked) begin
                poked = 1;
                tx_ready = 1'b0;
                cmd_we = 1'b1;
                cmd_wdata = cancel ? 32'h0 : 32'h4005;
                @(negedge clk);
                cmd_we = 1'b0; cmd_wdata = '0;
                if (cancel) begin
                    chk(!tx_valid && cmd_rdata == 32'h0, "R3 zero write cancels", cmd_rdata, 32'h0);
                    return;
                end
                chk(cmd_rdata[14] && cmd_rdata[10:0] == 11'(len), "R11 busy write ignored",
                    cmd_rdata, 32'(len) | 32'h4000);
                continue;
            end
            tx_ready = (($urandom % 4) != 0);
            #1;
            if (tx_valid && tx_ready) begin
                if (tx_data != pat(seed, got)) bad_d = 1;
                if (tx_last != (got == len - 1)) bad_last = 1;
                prevlast = tx_last;
                got++;
            end
            @(negedge clk);
        end
        tx_ready = 1'b0;
        chk(got == len, "R1 octet count", 32'(got), 32'(len));
        chk(!bad_d, "R6 transmit octet order", 32'(bad_d), 32'd0);
        chk(!bad_go && !bad_last, "R2 go held and last flag", {30'd0, bad_go, bad_last}, 32'd0);
    endtask

    task automatic rx_send(int len, bit crc, bit oth, int seed);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = pat(seed, k); rx_last = (k == len - 1);
            rx_crc_err = crc && (k == len - 1);
            rx_oth_err = oth && (k == len - 1);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0; rx_crc_err = 1'b0; rx_oth_err = 1'b0;
    endtask

    task automatic rx_mem_chk(int len, int seed, string req);
        int errs = 0;
        for (int k = 0; k < len; k++)
            if (mem_octet(rx_mem[k/4], k) != pat(seed, k)) errs++;
        chk(errs == 0, req, 32'(errs), 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        total++; bad++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < WORDS; i++) begin tx_mem[i] = '0; rx_mem[i] = '0; end
        rst = 1'b1; cmd_we = 0; cmd_wdata = 0; stat_clr = 0; tx_ready = 0;
        rx_valid = 0; rx_data = 0; rx_last = 0; rx_crc_err = 0; rx_oth_err = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R4 reset state
        chk(cmd_rdata == 32'h8000, "R4 command reset value", cmd_rdata, 32'h8000);
        chk(stat_rdata == 32'h0 && !rx_irq && !tx_valid, "R4 status reset value", stat_rdata, 32'h0);
        // R4 start refused while held
        cmd_write(32'hC00A);
        repeat (2) @(negedge clk);
        chk(cmd_rdata == 32'h800A && !tx_valid, "R4 start refused in hold", cmd_rdata, 32'h800A);
        rx_send(8, 0, 0, 5);
        chk(stat_rdata == 32'h0 && !rx_irq && rx_mem[0] == 32'h0, "R4 receive ignored in hold",
            stat_rdata, 32'h0);
        cmd_write(32'h0);
        chk(cmd_rdata == 32'h0, "R4 hold released", cmd_rdata, 32'h0);

        // R1 R2 R6 directed lengths
        tx_send(1, 0, 1, -1, 0);
        tx_send(4, 1, 2, -1, 0);
        tx_send(64, 2, 3, -1, 0);
        tx_send(7, 4, 4, -1, 0);
        // random lengths and options
        for (int i = 0; i < 6; i++) begin
            int len = 1 + int'($urandom % 300);
            int op  = int'($urandom % 8);
            if (op[1] && len < 64) len += 64;
            tx_send(len, op, 20 + i, -1, 0);
        end

        // R5 refused starts
        cmd_write(32'h0002_403F);
        repeat (2) @(negedge clk);
        chk(!cmd_rdata[14] && !tx_valid, "R5 raw crc short length refused", cmd_rdata, 32'h0002_003F);
        cmd_write(32'h0000_4000);
        chk(!cmd_rdata[14] && !tx_valid, "R5 zero length refused", cmd_rdata, 32'h0);

        // R11 ignored write, R3 cancel
        tx_send(100, 0, 9, 10, 0);
        tx_send(200, 0, 10, 10, 1);
        tx_send(3, 0, 11, -1, 0);

        // R7 R6 receive
        rx_send(23, 0, 0, 11);
        chk(stat_rdata == 32'h4017 && rx_irq, "R7 available and length", stat_rdata, 32'h4017);
        rx_mem_chk(23, 11, "R6 receive octet order");
        // R8 locked
        rx_send(30, 0, 0, 12);
        chk(stat_rdata == 32'hC017, "R8 missed flag set", stat_rdata, 32'hC017);
        rx_mem_chk(23, 11, "R8 locked memory untouched");
        // R10 clears
        stat_write(4'b0010);
        chk(stat_rdata == 32'h4017, "R10 missed cleared only", stat_rdata, 32'h4017);
        stat_write(4'b0000);
        chk(stat_rdata == 32'h4017, "R10 zero strobe no effect", stat_rdata, 32'h4017);
        stat_write(4'b0001);
        chk(!stat_rdata[14] && !rx_irq, "R10 rearm clears available", stat_rdata, 32'h0017);
        // R9 faults
        rx_send(40, 1, 0, 13);
        chk(stat_rdata[17:14] == 4'b0100, "R9 crc fault", stat_rdata, 32'h10000);
        rx_send(10, 1, 1, 14);
        chk(stat_rdata[17:14] == 4'b0100, "R9 crc priority", stat_rdata, 32'h10000);
        stat_write(4'b0100);
        rx_send(12, 0, 1, 15);
        chk(stat_rdata[17:14] == 4'b1000 && !rx_irq, "R9 other fault", stat_rdata, 32'h20000);
        stat_write(4'b1000);
        chk(stat_rdata[17:14] == 4'b0000, "R10 other cleared", stat_rdata, 32'h0);
        // R7 one octet packet
        rx_send(1, 0, 0, 16);
        chk(stat_rdata == 32'h4001, "R7 single octet packet", stat_rdata, 32'h4001);
        rx_mem_chk(1, 16, "R6 single octet lane");
        stat_write(4'b0001);
        // random receive
        for (int i = 0; i < 6; i++) begin
            int len = 1 + int'($urandom % 200);
            rx_send(len, 0, 0, 40 + i);
            chk(stat_rdata == (32'h4000 | 32'(len)), "R7 random packet", stat_rdata, 32'h4000 | 32'(len));
            rx_mem_chk(len, 40 + i, "R6 random packet contents");
            stat_write(4'b0001);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule